// File: doc/BRIEF.md
# DMA Transfer Request Queue Controller

This block is the register-programmed control front end of a single-channel DMA engine. Software stages a descriptor in a set of 32-bit registers: destination address, source address, row length, row count and flags. Writing the submit register pushes that descriptor into a small request queue. Each request receives a 5-bit transfer ID from a round-robin allocator. The queue hands requests to the data mover in order, through a valid/ready pair. The data mover reports each finished request with a one-cycle pulse and its ID.

Finished requests gather in a 32-bit completion mask, one bit per ID. A read of that register reports the finished IDs and acknowledges them. Two interrupt events are tracked in a pending register that software clears by writing ones:

- start of transfer, raised when the data mover takes a request from the queue;
- end of transfer, raised when a completion is accepted.

A mask register gates these events onto the interrupt line. Software can find out which optional features are present by writing a register and reading it back. This works for the cyclic flag, the row-count register and the row-length width.

The register port uses a word index `reg_addr` (byte offset divided by 4). The word indices are:

| Index | Register |
|---|---|
| 0 | control |
| 1 | next transfer ID |
| 2 | submit |
| 3 | flags |
| 4 | destination address |
| 5 | source address |
| 6 | row length |
| 7 | row count |
| 8 | completion mask |
| 9 | interrupt mask |
| 10 | interrupt pending |
| 11 | masked interrupt status |

Reads return data in the same cycle, and any unmapped index reads 0.

Top module: `dma_req_queue`

## Requirements
- R1: Control bit 0 enables the engine and control bit 1 pauses it. No request is offered (`xfer_valid` low) while the engine is disabled or paused. Writing the control register with bit 0 clear empties the queue, forgets every outstanding ID and clears the completion mask. The next-ID counter keeps its value.
- R2: Writing the submit register (index 2) with bit 0 set pushes the staged descriptor, tagged with the current next ID. Reading the submit register returns 1 while a submit would be refused and 0 otherwise. A submit is refused when the engine is disabled, when the queue is full, or when the next ID is still outstanding. A refused submit changes nothing.
- R3: The queue holds DEPTH requests and presents them in submission order on `xfer_*`. A request leaves the queue in a cycle where `xfer_valid` and `xfer_ready` are both high.
- R4: The next-ID register (index 1) reads the ID the next accepted submit will get. It starts at 0, advances by one per accepted submit, and wraps from 31 to 0.
- R5: An ID stays outstanding from its submit until a completion-mask read has reported it. While the next ID is outstanding, submits are refused.
- R6: A `done_pulse` with an outstanding, not yet completed `done_id` sets bit `done_id` of the completion mask (index 8). Any other pulse is ignored. A read of the mask returns it and clears exactly the bits it returned. A completion that arrives in the same cycle as the read is kept.
- R7: Interrupt-pending (index 10) has two event bits. Bit 0 is set by each dispatch (start of transfer) and bit 1 by each accepted completion (end of transfer). Writing 1 to a bit clears it, and an event in the same cycle as the clear wins.
- R8: Interrupt-mask (index 9) resets to 3, with all sources masked. `irq` is the OR of the pending bits whose mask bit is 0. Index 11 reads pending AND NOT mask.
- R9: Flags (index 3) hold three bits: cyclic (bit 0), last (bit 1) and partial-report enable (bit 2). Each submitted request carries the flags on `xfer_flags`. With HAS_CYCLIC=0 the cyclic bit reads back 0 after a write of 1.
- R10: The row-length register keeps only its low XLEN_W bits. With HAS_2D=0 the row-count register reads back 0 after any write, and `xfer_ylen` is 0.
- R11: After reset the following hold:
  - control, next ID, completion mask and pending all read 0;
  - the mask reads 3;
  - submit reads 1;
  - `irq` and `xfer_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as `reg_rd` |
| irq | output | 1 | Interrupt request |
| xfer_valid | output | 1 | Queue head offered to the data mover |
| xfer_ready | input | 1 | Data mover takes the head request |
| xfer_id | output | 5 | Transfer ID of the head request |
| xfer_flags | output | 3 | Flags of the head request |
| xfer_dst | output | 32 | Destination address |
| xfer_src | output | 32 | Source address |
| xfer_xlen | output | 32 | Row length field |
| xfer_ylen | output | 32 | Row count field |
| done_pulse | input | 1 | One-cycle completion report |
| done_id | input | 5 | ID of the completed request |

## Verification
The hardest case to reach is the refusal caused by an ID that is still outstanding. With a four-entry queue, the queue-full check normally blocks submits long before the allocator wraps. To reach it, the bench runs 32 rounds of submit, dispatch and completion without ever reading the completion mask, so the allocator comes back to an ID that has not been acknowledged. Two other cases are driven deliberately: a pending-clear write in the same clock as a dispatch, and completions for IDs that were never issued or were flushed by a disable.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

  localparam int ID_W    = 5;
  localparam int NUM_IDS = 1 << ID_W;
  localparam int DW      = 32;
  localparam int FLG_W   = 3;
  localparam int IRQ_W   = 2;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [FLG_W-1:0] flags;
    logic [DW-1:0]    dst;
    logic [DW-1:0]    src;
    logic [DW-1:0]    xlen;
    logic [DW-1:0]    ylen;
  } dmaq_desc_t;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_NEXTID = 4'd1,
    RA_SUBMIT = 4'd2,
    RA_FLAGS  = 4'd3,
    RA_DST    = 4'd4,
    RA_SRC    = 4'd5,
    RA_XLEN   = 4'd6,
    RA_YLEN   = 4'd7,
    RA_DONE   = 4'd8,
    RA_IMASK  = 4'd9,
    RA_IPEND  = 4'd10,
    RA_ISRC   = 4'd11
  } dmaq_reg_e;

endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  dmaq_desc_t din,
  input  logic       pop,
  output dmaq_desc_t dout,
  output logic       empty,
  output logic       full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  dmaq_desc_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign dout  = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
      if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem_q[wr_q] <= din;
  end

  // R3
  fifo_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R3
  fifo_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/dmaq_ids.sv
module dmaq_ids
  import dmaq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               issue,
  input  logic               done_pulse,
  input  logic [ID_W-1:0]    done_id,
  input  logic               ack,
  output logic [ID_W-1:0]    next_id,
  output logic               id_busy,
  output logic [NUM_IDS-1:0] done_mask,
  output logic               done_accept
);

  logic [NUM_IDS-1:0] inuse_q, inuse_d, done_q, done_d;
  logic [NUM_IDS-1:0] reported, set_v, iss_v;
  logic [ID_W-1:0]    nid_q, nid_d;

  assign next_id     = nid_q;
  assign id_busy     = inuse_q[nid_q];
  assign done_mask   = done_q;
  assign done_accept = done_pulse && !flush && inuse_q[done_id] && !done_q[done_id];

  always_comb begin
    reported = ack ? done_q : '0;
    set_v    = done_accept ? (NUM_IDS'(1) << done_id) : '0;
    iss_v    = issue ? (NUM_IDS'(1) << nid_q) : '0;
    nid_d    = issue ? nid_q + ID_W'(1) : nid_q;
    if (flush) begin
      inuse_d = '0;
      done_d  = '0;
    end else begin
      inuse_d = (inuse_q & ~reported) | iss_v;
      done_d  = (done_q & ~reported) | set_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inuse_q <= '0;
      done_q  <= '0;
      nid_q   <= '0;
    end else begin
      inuse_q <= inuse_d;
      done_q  <= done_d;
      nid_q   <= nid_d;
    end
  end

  // R6
  done_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q & ~inuse_q) == '0);

  // R4
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> nid_q == $past(nid_q) + ID_W'(1));

  // R5
  no_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !inuse_q[nid_q]);

endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq
  import dmaq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sot_ev,
  input  logic             eot_ev,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] pend,
  output logic             irq
);

  logic [IRQ_W-1:0] mask_q, mask_d, pend_q, pend_d, clr_v;

  assign mask = mask_q;
  assign pend = pend_q;
  assign irq  = |(pend_q & ~mask_q);

  always_comb begin
    clr_v  = clr_we ? wbits : '0;
    mask_d = mask_we ? wbits : mask_q;
    pend_d = (pend_q & ~clr_v) | {eot_ev, sot_ev};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  // R7
  sot_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sot_ev |=> pend_q[0]);

  // R7
  eot_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_ev |=> pend_q[1]);

endmodule

// File: rtl/dma_req_queue.sv
module dma_req_queue
  import dmaq_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int XLEN_W     = 24,
  parameter bit HAS_CYCLIC = 1'b1,
  parameter bit HAS_2D     = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        xfer_valid,
  input  logic        xfer_ready,
  output logic [4:0]  xfer_id,
  output logic [2:0]  xfer_flags,
  output logic [31:0] xfer_dst,
  output logic [31:0] xfer_src,
  output logic [31:0] xfer_xlen,
  output logic [31:0] xfer_ylen,
  input  logic        done_pulse,
  input  logic [4:0]  done_id
);

  localparam logic [DW-1:0] XLEN_MASK = {DW{1'b1}} >> (DW - XLEN_W);

  logic              en_q, en_d, pause_q, pause_d;
  logic [DW-1:0]     dst_q, dst_d, src_q, src_d, xlen_q, xlen_d, ylen_val;
  logic [FLG_W-1:0]  flags_q, flags_d;
  logic              cyc_bit;
  logic              ctrl_we, flush, sub_busy, sub_fire, pop, done_ack;
  logic              fifo_empty, fifo_full, id_busy, done_acc;
  logic [ID_W-1:0]   nid;
  logic [NUM_IDS-1:0] done_mask;
  logic [IRQ_W-1:0]  imask, ipend;
  dmaq_desc_t        push_desc, head;

  // write decode
  assign ctrl_we  = reg_wr && (reg_addr == RA_CTRL);
  assign flush    = ctrl_we && !reg_wdata[0];
  assign sub_busy = !en_q || fifo_full || id_busy;
  assign sub_fire = reg_wr && (reg_addr == RA_SUBMIT) && reg_wdata[0] && !sub_busy;
  assign done_ack = reg_rd && (reg_addr == RA_DONE);

  generate
    if (HAS_CYCLIC) begin : g_cyc
      assign cyc_bit = reg_wdata[0];
    end else begin : g_nocyc
      assign cyc_bit = 1'b0;
    end
  endgenerate

  always_comb begin
    en_d    = en_q;
    pause_d = pause_q;
    dst_d   = dst_q;
    src_d   = src_q;
    xlen_d  = xlen_q;
    flags_d = flags_q;
    if (reg_wr) begin
      case (reg_addr)
        RA_CTRL:  begin en_d = reg_wdata[0]; pause_d = reg_wdata[1]; end
        RA_FLAGS: flags_d = {reg_wdata[2:1], cyc_bit};
        RA_DST:   dst_d   = reg_wdata;
        RA_SRC:   src_d   = reg_wdata;
        RA_XLEN:  xlen_d  = reg_wdata & XLEN_MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      dst_q   <= '0;
      src_q   <= '0;
      xlen_q  <= '0;
      flags_q <= '0;
    end else begin
      en_q    <= en_d;
      pause_q <= pause_d;
      dst_q   <= dst_d;
      src_q   <= src_d;
      xlen_q  <= xlen_d;
      flags_q <= flags_d;
    end
  end

  generate
    if (HAS_2D) begin : g_2d
      logic [DW-1:0] ylen_q, ylen_d;
      always_comb begin
        ylen_d = (reg_wr && reg_addr == RA_YLEN) ? reg_wdata : ylen_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ylen_q <= '0;
        else        ylen_q <= ylen_d;
      end
      assign ylen_val = ylen_q;
    end else begin : g_1d
      assign ylen_val = '0;
    end
  endgenerate

  always_comb begin
    push_desc.id    = nid;
    push_desc.flags = flags_q;
    push_desc.dst   = dst_q;
    push_desc.src   = src_q;
    push_desc.xlen  = xlen_q;
    push_desc.ylen  = ylen_val;
  end

  dmaq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (sub_fire),
    .din   (push_desc),
    .pop   (pop),
    .dout  (head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  dmaq_ids u_ids (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .issue       (sub_fire),
    .done_pulse  (done_pulse),
    .done_id     (done_id),
    .ack         (done_ack),
    .next_id     (nid),
    .id_busy     (id_busy),
    .done_mask   (done_mask),
    .done_accept (done_acc)
  );

  dmaq_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sot_ev  (pop),
    .eot_ev  (done_acc),
    .mask_we (reg_wr && (reg_addr == RA_IMASK)),
    .clr_we  (reg_wr && (reg_addr == RA_IPEND)),
    .wbits   (reg_wdata[IRQ_W-1:0]),
    .mask    (imask),
    .pend    (ipend),
    .irq     (irq)
  );

  // dispatch side
  assign xfer_valid = en_q && !pause_q && !fifo_empty;
  assign pop        = xfer_valid && xfer_ready;
  assign xfer_id    = head.id;
  assign xfer_flags = head.flags;
  assign xfer_dst   = head.dst;
  assign xfer_src   = head.src;
  assign xfer_xlen  = head.xlen;
  assign xfer_ylen  = head.ylen;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        RA_CTRL:   reg_rdata = {30'd0, pause_q, en_q};
        RA_NEXTID: reg_rdata = {{(DW-ID_W){1'b0}}, nid};
        RA_SUBMIT: reg_rdata = {31'd0, sub_busy};
        RA_FLAGS:  reg_rdata = {{(DW-FLG_W){1'b0}}, flags_q};
        RA_DST:    reg_rdata = dst_q;
        RA_SRC:    reg_rdata = src_q;
        RA_XLEN:   reg_rdata = xlen_q;
        RA_YLEN:   reg_rdata = ylen_val;
        RA_DONE:   reg_rdata = done_mask;
        RA_IMASK:  reg_rdata = {{(DW-IRQ_W){1'b0}}, imask};
        RA_IPEND:  reg_rdata = {{(DW-IRQ_W){1'b0}}, ipend};
        RA_ISRC:   reg_rdata = {{(DW-IRQ_W){1'b0}}, ipend & ~imask};
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R1
  disabled_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> fifo_empty);

  // R2
  refused_submit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_SUBMIT && reg_wdata[0] && sub_busy) |=> $stable(nid));

endmodule

// File: tb/dma_req_queue_tb.sv
module dma_req_queue_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, xfer_valid, xfer_ready;
  logic [4:0]  xfer_id;
  logic [2:0]  xfer_flags;
  logic [31:0] xfer_dst, xfer_src, xfer_xlen, xfer_ylen;
  logic        done_pulse;
  logic [4:0]  done_id;

  int total = 0;
  int bad   = 0;
  logic [31:0] rv;

  localparam logic [3:0] A_CTRL = 4'd0, A_NID = 4'd1, A_SUB = 4'd2, A_FLG = 4'd3,
                         A_DST = 4'd4, A_SRC = 4'd5, A_XLEN = 4'd6, A_YLEN = 4'd7,
                         A_DONE = 4'd8, A_MASK = 4'd9, A_PEND = 4'd10, A_ISRC = 4'd11;

  always #10 clk = ~clk;

  dma_req_queue u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_id(xfer_id), .xfer_flags(xfer_flags),
    .xfer_dst(xfer_dst), .xfer_src(xfer_src), .xfer_xlen(xfer_xlen),
    .xfer_ylen(xfer_ylen), .done_pulse(done_pulse), .done_id(done_id)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic done(input logic [4:0] id);
    @(negedge clk);
    done_pulse = 1'b1; done_id = id;
    @(negedge clk);
    done_pulse = 1'b0;
  endtask

  task automatic pop_one(input string tag, input logic [4:0] id,
                         input logic [31:0] xl, input logic [2:0] fl);
    @(negedge clk);
    check({tag, " valid"}, {31'd0, xfer_valid}, 32'd1);
    check({tag, " id"}, {27'd0, xfer_id}, {27'd0, id});
    check({tag, " xlen"}, xfer_xlen, xl);
    check({tag, " flags"}, {29'd0, xfer_flags}, {29'd0, fl});
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
  endtask

  task automatic t_reset;
    rd(A_CTRL, rv); check("R11 ctrl", rv, 0);
    rd(A_NID, rv);  check("R11 nextid", rv, 0);
    rd(A_SUB, rv);  check("R11/R2 submit busy when disabled", rv, 1);
    rd(A_MASK, rv); check("R11/R8 mask reset", rv, 3);
    rd(A_PEND, rv); check("R11 pend", rv, 0);
    rd(A_DONE, rv); check("R11 done", rv, 0);
    check("R11 irq", {31'd0, irq}, 0);
    check("R11 xfer_valid", {31'd0, xfer_valid}, 0);
  endtask

  task automatic t_probe;
    wr(A_FLG, 32'h7);        rd(A_FLG, rv);  check("R9 flags readback", rv, 7);
    wr(A_YLEN, 32'h5);       rd(A_YLEN, rv); check("R10 ylen absent", rv, 0);
    wr(A_XLEN, 32'hFFFFFFFF); rd(A_XLEN, rv); check("R10 xlen width", rv, 32'h00FFFFFF);
  endtask

  task automatic t_submit_order;
    wr(A_CTRL, 1);
    wr(A_DST, 32'hA000); wr(A_SRC, 32'hB000);
    for (int k = 0; k < 4; k++) begin
      wr(A_XLEN, 32'h100 + k);
      wr(A_FLG, k);
      wr(A_SUB, 1);
    end
    rd(A_SUB, rv); check("R2 submit busy when full", rv, 1);
    wr(A_SUB, 1);
    rd(A_NID, rv); check("R2/R4 refused submit keeps id", rv, 4);
    wr(A_CTRL, 3);
    check("R1 paused no dispatch", {31'd0, xfer_valid}, 0);
    wr(A_CTRL, 1);
    check("R3 dst", xfer_dst, 32'hA000);
    for (int k = 0; k < 4; k++) pop_one("R3/R9 order", 5'(k), 32'h100 + k, 3'(k));
    check("R3 queue drained", {31'd0, xfer_valid}, 0);
    rd(A_PEND, rv); check("R7 sot pending", rv, 1);
  endtask

  task automatic t_done_irq;
    done(2); done(0);
    check("R8 irq masked", {31'd0, irq}, 0);
    rd(A_DONE, rv); check("R6 done mask", rv, 32'h5);
    wr(A_MASK, 0);
    check("R8 irq unmasked", {31'd0, irq}, 1);
    rd(A_ISRC, rv); check("R8 masked status", rv, 3);
    wr(A_PEND, 1); rd(A_PEND, rv); check("R7 w1c bit0", rv, 2);
    wr(A_PEND, 2); rd(A_PEND, rv); check("R7 w1c bit1", rv, 0);
    check("R8 irq cleared", {31'd0, irq}, 0);
    rd(A_DONE, rv); check("R6 read clears", rv, 0);
    done(9);
    rd(A_DONE, rv); check("R6 unknown id ignored", rv, 0);
    rd(A_PEND, rv); check("R6 unknown id no eot", rv, 0);
    done(1); done(3);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = A_DONE; done_pulse = 1'b1; done_id = 5'd1;
    #1 rv = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; done_pulse = 1'b0;
    check("R6 mask 1,3", rv, 32'hA);
    rd(A_DONE, rv); check("R6 duplicate after report ignored", rv, 0);
    wr(A_PEND, 3);
  endtask

  task automatic t_id_reuse;
    for (int k = 0; k < 32; k++) begin
      logic [4:0] id;
      id = 5'(k + 4);
      wr(A_SUB, 1);
      pop_one("R5 loop", id, 32'h103, 3'd3);
      done(id);
      if (id == 5'd31) begin
        rd(A_NID, rv); check("R4 wrap to 0", rv, 0);
      end
    end
    rd(A_SUB, rv); check("R5 next id outstanding", rv, 1);
    wr(A_SUB, 1);
    rd(A_NID, rv); check("R5 refused keeps id", rv, 4);
    check("R5 nothing queued", {31'd0, xfer_valid}, 0);
    rd(A_DONE, rv); check("R6 all done", rv, 32'hFFFFFFFF);
    rd(A_SUB, rv); check("R5 released after report", rv, 0);
    wr(A_PEND, 3);
  endtask

  task automatic t_disable;
    wr(A_SUB, 1); wr(A_SUB, 1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_PEND; reg_wdata = 1; xfer_ready = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; xfer_ready = 1'b0;
    rd(A_PEND, rv); check("R7 event beats clear", rv, 1);
    wr(A_CTRL, 0);
    check("R1 disabled no dispatch", {31'd0, xfer_valid}, 0);
    rd(A_SUB, rv); check("R1 submit busy disabled", rv, 1);
    wr(A_CTRL, 1);
    check("R1 queue flushed", {31'd0, xfer_valid}, 0);
    rd(A_SUB, rv); check("R1 ids released", rv, 0);
    done(4);
    rd(A_DONE, rv); check("R1 flushed id done ignored", rv, 0);
    rd(A_NID, rv); check("R1 next id kept", rv, 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    xfer_ready = 0; done_pulse = 0; done_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_probe;
    t_submit_order;
    t_done_irq;
    t_id_reuse;
    t_disable;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule